// File: doc/BRIEF.md
# Sound Coprocessor Interval Timer

This block is one programmable interval timer for a sound coprocessor. The coprocessor reaches it through a simple register bus with an address, a write strobe, a read strobe and write data. A control register holds the run bit. A target register sets the period. A small event counter tells the program how many periods have passed since it last looked.

While the timer runs, each pulse on the prescaled tick input advances an internal stage counter. When the stage counter completes one period, it returns to zero and the event counter goes up by one. The program polls the event counter. Each read hands back the count and empties it, so the program sees only the events that arrived since its previous read. Turning the timer on from the off state restarts both counters.

Top module: `snd_interval_timer`

## Requirements
- R1: After reset the timer is stopped, the event counter holds 0, and `bus_rdata` is 0.
- R2: Bit 0 of a write to control address 0xF1 sets the run bit. Ticks have no effect while this bit is 0, and the event counter keeps its value.
- R3: A write to address 0xFA loads the 8-bit target. While running, the event counter goes up by one on every target-th tick. With a target of 4, 12 ticks give a count of 3.
- R4: A read at address 0xFD puts the event counter on `bus_rdata[3:0]` in the same cycle. The counter is 0 from the next cycle on.
- R5: The event counter is 4 bits wide and wraps from 15 to 0. `bus_rdata[7:4]` is always 0, so a read never exceeds 0x0F.
- R6: A target of 0 gives a period of 256 ticks.
- R7: A write to 0xF1 that takes the run bit from 0 to 1 clears both the stage counter and the event counter. A write that leaves the bit at 1 clears neither.
- R8: If a read of 0xFD and a wrapping tick fall in the same cycle, the read returns the old count and the counter then holds 1.
- R9: `bus_rdata` is 0 in any cycle without a read strobe at 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle prescaled tick pulse |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |

## Verification
The assertions assume that the tick is a single-cycle pulse sampled on the clock, and that a read and a write do not fall in the same cycle. The stimulus drives every strobe for exactly one cycle and changes inputs only on the falling edge. It never raises the read and write strobes together. The only overlap it creates on purpose is a tick arriving together with a read of the event counter.

// File: rtl/snd_tmr_pkg.sv
package snd_tmr_pkg;
   localparam int unsigned BUS_ADDR_W = 8;
   localparam int unsigned BUS_DATA_W = 8;
   localparam logic [BUS_ADDR_W-1:0] ADDR_CTRL  = 8'hF1;
   localparam logic [BUS_ADDR_W-1:0] ADDR_TGT   = 8'hFA;
   localparam logic [BUS_ADDR_W-1:0] ADDR_COUNT = 8'hFD;

   typedef struct packed {
      logic ctrl_wr;
      logic tgt_wr;
      logic cnt_rd;
   } tmr_sel_t;
endpackage

// File: rtl/snd_tmr_regs.sv
module snd_tmr_regs
   import snd_tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = BUS_ADDR_W,
   parameter int unsigned DATA_W = BUS_DATA_W,
   parameter int unsigned TGT_W = 8,
   parameter int unsigned EN_BIT = 0,
   parameter logic [ADDR_W-1:0] CTRL_A = ADDR_CTRL,
   parameter logic [ADDR_W-1:0] TGT_A = ADDR_TGT,
   parameter logic [ADDR_W-1:0] CNT_A = ADDR_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output tmr_sel_t          sel,
   output logic              run,
   output logic              run_rise,
   output logic [TGT_W-1:0]  target
);
   initial begin
      if (EN_BIT >= DATA_W) $error("EN_BIT outside data width");
      if (TGT_W > DATA_W) $error("target wider than data bus");
      if (CTRL_A == TGT_A || CTRL_A == CNT_A || TGT_A == CNT_A)
         $error("register addresses must differ");
   end

   always_comb begin
      sel.ctrl_wr = wr && (addr == CTRL_A);
      sel.tgt_wr  = wr && (addr == TGT_A);
      sel.cnt_rd  = rd && (addr == CNT_A);
   end

   assign run_rise = sel.ctrl_wr && wdata[EN_BIT] && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         target <= '0;
      end else begin
         if (sel.ctrl_wr) run <= wdata[EN_BIT];
         if (sel.tgt_wr) target <= wdata[TGT_W-1:0];
      end
   end

   // R7: a rising run write leaves the timer running
   a_r7_rise_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
      run_rise |=> run);
   // R2: run changes only through a control write
   a_r2_run_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !sel.ctrl_wr |=> $stable(run));
endmodule

// File: rtl/snd_tmr_stage.sv
module snd_tmr_stage #(
   parameter int unsigned TGT_W = 8,
   parameter bit ZERO_IS_FULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clear,
   input  logic [TGT_W-1:0] target,
   output logic             wrap
);
   logic [TGT_W-1:0] stage;
   logic             hit;

   initial begin
      if (TGT_W < 2 || TGT_W > 16) $error("TGT_W out of range");
   end

   generate
      if (ZERO_IS_FULL) begin : g_zero_full
         // target-1 wraps to all ones, so zero selects the full span
         assign hit = (stage == TGT_W'(target - 1'b1));
      end else begin : g_zero_stop
         assign hit = (target != '0) && (stage == TGT_W'(target - 1'b1));
      end
   endgenerate

   assign wrap = run && tick && hit && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '0;
      else if (clear) stage <= '0;
      else if (run && tick) stage <= hit ? '0 : stage + 1'b1;
   end

   // R2: stopped timer keeps its stage
   a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(stage));
   // R7: rising run clears the stage
   a_r7_stage_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> stage == '0);
   // R3: stage returns to zero after a period ends
   a_r3_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> stage == '0);
endmodule

// File: rtl/snd_tmr_count.sv
module snd_tmr_count #(
   parameter int unsigned OUT_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic              clear,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata
);
   logic [OUT_W-1:0] count;

   initial begin
      if (OUT_W < 1 || OUT_W > DATA_W) $error("OUT_W must fit the data bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else if (clear) count <= '0;
      else if (rd) count <= wrap ? OUT_W'(1) : '0;
      else if (wrap) count <= count + 1'b1;
   end

   generate
      if (OUT_W == DATA_W) begin : g_full
         assign rdata = rd ? count : '0;
      end else begin : g_pad
         assign rdata = rd ? {{(DATA_W-OUT_W){1'b0}}, count} : '0;
      end
   endgenerate

   // R4: read without a new event empties the counter
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wrap && !clear) |=> count == '0);
   // R8: read together with an event leaves exactly one
   a_r8_read_and_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && wrap && !clear) |=> count == OUT_W'(1));
   // R3: each event adds one, wrapping at the width (R5)
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !rd && !clear) |=> count == OUT_W'($past(count) + 1'b1));
   // R9: idle bus returns zero
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> rdata == '0);
endmodule

// File: rtl/snd_interval_timer.sv
module snd_interval_timer
   import snd_tmr_pkg::*;
#(
   parameter int unsigned TGT_W = 8,
   parameter int unsigned OUT_W = 4,
   parameter int unsigned EN_BIT = 0,
   parameter bit ZERO_IS_FULL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [BUS_DATA_W-1:0] bus_wdata,
   output logic [BUS_DATA_W-1:0] bus_rdata
);
   tmr_sel_t         sel;
   logic             run;
   logic             run_rise;
   logic             wrap;
   logic [TGT_W-1:0] target;

   snd_tmr_regs #(
      .ADDR_W(BUS_ADDR_W), .DATA_W(BUS_DATA_W), .TGT_W(TGT_W), .EN_BIT(EN_BIT),
      .CTRL_A(ADDR_CTRL), .TGT_A(ADDR_TGT), .CNT_A(ADDR_COUNT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .sel(sel), .run(run), .run_rise(run_rise),
      .target(target)
   );

   snd_tmr_stage #(.TGT_W(TGT_W), .ZERO_IS_FULL(ZERO_IS_FULL)) u_stage (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clear(run_rise),
      .target(target), .wrap(wrap)
   );

   snd_tmr_count #(.OUT_W(OUT_W), .DATA_W(BUS_DATA_W)) u_count (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .clear(run_rise),
      .rd(sel.cnt_rd), .rdata(bus_rdata)
   );

   // R2: no period ends while stopped
   a_r2_no_wrap_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !wrap);
   // R5: upper read bits stay zero
   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_DATA_W-1:OUT_W] == '0);
endmodule

// File: tb/snd_interval_timer_test.sv
module snd_interval_timer_test;
   localparam time CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   snd_interval_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic restart(logic [7:0] tgt);
      logic [7:0] d;
      wr(8'hF1, 8'h00);
      wr(8'hFA, tgt);
      wr(8'hF1, 8'h01);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 rdata idle after reset", bus_rdata, 8'h00);
      ticks(5);
      rd(8'hFD, d);
      check("R1 count zero after reset", d, 8'h00);
   endtask

   task automatic t_disabled;
      logic [7:0] d;
      restart(8'd2);
      ticks(6);
      wr(8'hF1, 8'h00);
      ticks(10);
      rd(8'hFD, d);
      check("R2 count held while stopped", d, 8'h03);
   endtask

   task automatic t_target4;
      logic [7:0] d;
      restart(8'd4);
      ticks(3);
      rd(8'hFD, d);
      check("R3 no event before period", d, 8'h00);
      ticks(1);
      rd(8'hFD, d);
      check("R3 event after 4 ticks", d, 8'h01);
      ticks(12);
      rd(8'hFD, d);
      check("R3 three events in 12 ticks", d, 8'h03);
   endtask

   task automatic t_read_clear;
      logic [7:0] d;
      restart(8'd1);
      ticks(5);
      rd(8'hFD, d);
      check("R4 read value", d, 8'h05);
      rd(8'hFD, d);
      check("R4 second read empty", d, 8'h00);
   endtask

   task automatic t_wrap;
      logic [7:0] d;
      restart(8'd1);
      ticks(17);
      rd(8'hFD, d);
      check("R5 wraps past 15", d, 8'h01);
      ticks(15);
      rd(8'hFD, d);
      check("R5 max value 0x0F", d, 8'h0F);
   endtask

   task automatic t_zero_target;
      logic [7:0] d;
      restart(8'd0);
      ticks(255);
      rd(8'hFD, d);
      check("R6 no event at 255", d, 8'h00);
      ticks(1);
      rd(8'hFD, d);
      check("R6 event at 256", d, 8'h01);
   endtask

   task automatic t_rise;
      logic [7:0] d;
      restart(8'd4);
      ticks(7);
      wr(8'hF1, 8'h01);
      ticks(1);
      rd(8'hFD, d);
      check("R7 run rewrite keeps stage and count", d, 8'h02);
      ticks(3);
      wr(8'hF1, 8'h00);
      wr(8'hF1, 8'h01);
      ticks(3);
      rd(8'hFD, d);
      check("R7 restart clears stage", d, 8'h00);
      ticks(5);
      wr(8'hF1, 8'h00);
      wr(8'hF1, 8'h01);
      rd(8'hFD, d);
      check("R7 restart clears count", d, 8'h00);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      restart(8'd2);
      ticks(3);
      @(negedge clk);
      tick = 1'b1; bus_addr = 8'hFD; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      tick = 1'b0; bus_rd = 1'b0;
      check("R8 read returns old count", d, 8'h01);
      rd(8'hFD, d);
      check("R8 new event kept", d, 8'h01);
   endtask

   task automatic t_idle;
      logic [7:0] d;
      restart(8'd1);
      ticks(3);
      rd(8'hFA, d);
      check("R9 other address reads zero", d, 8'h00);
      @(negedge clk);
      #1 check("R9 no strobe reads zero", bus_rdata, 8'h00);
      rd(8'hFD, d);
      check("R9 count untouched by other read", d, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_disabled();
      t_target4();
      t_read_clear();
      t_wrap();
      t_zero_target();
      t_rise();
      t_collide();
      t_idle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule